// File: doc/BRIEF.md
# Sixteen-Pin Serially Controlled I/O Expander Register Core

This block holds the register state of a sixteen-pin I/O expander that is reached over a two-wire serial bus. A separate target front end handles the bus at the bit level and hands this core one strobe per byte. Every transaction opens with a command byte, which chooses the register that later bytes address. Data bytes written after it load the selected register. Data bytes read after it are taken from `rd_data`. After each data byte the command pointer moves to the other half of the register pair, so a host can move a whole 16-bit value in one burst.

The core stores an output latch and a direction register. It drives the pin output values and output enables from them. The pin levels pass through a two-flop synchronizer and are readable at all times. The core also drives an active-low interrupt. The interrupt goes low when a pin configured as an input no longer matches the level it had at its last read.

Top module: `gpx_core`

## Requirements
- R1: After reset the direction register is 0xFFFF (all pins inputs), the output latch is 0xFFFF, `pin_oe` and `pin_out` are 0, `int_n` is high, and the command pointer is 0.
- R2: A `cmd_we` strobe stores `wdata` as the command pointer. A `dat_we` strobe writes `wdata` into the byte that the pointer selects. `rd_data` always shows the selected byte. Map: 0/1 = input port low/high, 2/3 = output latch low/high, 6/7 = direction low/high. In the direction register, 1 = input and 0 = output.
- R3: Each `dat_we` or `rd_ack` strobe flips bit 0 of the pointer. A burst therefore alternates between the two bytes of a pair and wraps back to the first byte.
- R4: Reads of pointer 0/1 return the synchronized pin levels (low byte = pins 0-7), whatever the pin direction. Data writes to pointer 0/1 change no register.
- R5: `pin_oe` is the inverse of the direction register. `pin_out` carries the output latch bit for output pins and 0 for input pins.
- R6: `int_n` goes low two clock edges after an input-configured pin changes away from the level recorded at its last read. That record is first taken when the synchronizer fills after reset.
- R7: A level change on an output-configured pin never drives `int_n` low.
- R8: A read strobe on input byte 0 or 1 records the current levels of that byte only. This clears an interrupt caused by that byte and leaves an interrupt caused by the other byte pending.
- R9: `int_n` returns high without a read once the changed input pin goes back to its recorded level.
- R10: Pointer values outside the map read as 0x00, and data writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_we | input | 1 | Command byte strobe from the bus front end |
| dat_we | input | 1 | Data byte write strobe |
| rd_ack | input | 1 | Data byte read strobe; `rd_data` was taken by the host |
| wdata | input | 8 | Byte for command or data write |
| rd_data | output | 8 | Byte that the pointer currently selects |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin output enables, active high |
| int_n | output | 1 | Interrupt request, active low, open-drain style |

## Verification
The checker assumes the front end raises no more than one of `cmd_we`, `dat_we` and `rd_ack` in any cycle, because it expects the pointer to flip after every data strobe. The bench drives each strobe for exactly one cycle from its byte tasks, changes inputs only on falling edges, and never overlaps two strobes. The pin inputs are treated as asynchronous. The bench holds each pin value steady for several cycles, so the two-edge synchronizer delay can be sampled exactly.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    GRP_IN   = 2'd0,
    GRP_OUT  = 2'd1,
    GRP_DIR  = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  // Pair base addresses; bit 0 of the pointer picks the byte in a pair.
  localparam logic [BYTE_W-2:0] PAIR_IN  = 7'd0;
  localparam logic [BYTE_W-2:0] PAIR_OUT = 7'd1;
  localparam logic [BYTE_W-2:0] PAIR_DIR = 7'd3;

  function automatic grp_e grp_of(logic [BYTE_W-1:0] ptr);
    case (ptr[BYTE_W-1:1])
      PAIR_IN:  grp_of = GRP_IN;
      PAIR_OUT: grp_of = GRP_OUT;
      PAIR_DIR: grp_of = GRP_DIR;
      default:  grp_of = GRP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int NPINS = 16,
  localparam int NBYTES = NPINS / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              dat_we,
  input  logic              rd_ack,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [NPINS-1:0]  pin_lvl,
  output logic [BYTE_W-1:0] ptr_q,
  output logic [BYTE_W-1:0] rd_data,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  cfg_q,
  output logic [NBYTES-1:0] in_rd
);
  grp_e              grp;
  logic [BYTE_W-1:0] ptr_d;
  logic [NPINS-1:0]  out_d;
  logic [NPINS-1:0]  cfg_d;
  logic              ptr_en;
  logic              out_en;
  logic              cfg_en;
  int                lane;

  assign grp  = grp_of(ptr_q);
  assign lane = int'(ptr_q[0]) * BYTE_W;

  // Read steering
  always_comb begin
    case (grp)
      GRP_IN:  rd_data = pin_lvl[lane +: BYTE_W];
      GRP_OUT: rd_data = out_q[lane +: BYTE_W];
      GRP_DIR: rd_data = cfg_q[lane +: BYTE_W];
      default: rd_data = '0;
    endcase
  end

  // Pointer next state: a command load has priority over pair toggling
  always_comb begin
    ptr_en = cmd_we | dat_we | rd_ack;
    if (cmd_we) begin
      ptr_d = wdata;
    end else begin
      ptr_d = {ptr_q[BYTE_W-1:1], ~ptr_q[0]};
    end
  end

  // Register write next state
  always_comb begin
    out_en = dat_we & ~cmd_we & (grp == GRP_OUT);
    cfg_en = dat_we & ~cmd_we & (grp == GRP_DIR);
    out_d  = out_q;
    cfg_d  = cfg_q;
    out_d[lane +: BYTE_W] = wdata;
    cfg_d[lane +: BYTE_W] = wdata;
  end

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_inrd
      assign in_rd[b] = rd_ack & ~cmd_we & (grp == GRP_IN) & (int'(ptr_q[0]) == b);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      out_q <= '1;
      cfg_q <= '1;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      if (out_en) out_q <= out_d;
      if (cfg_en) cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq
  import gpx_pkg::*;
#(
  parameter int NPINS = 16,
  localparam int NBYTES = NPINS / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic [NPINS-1:0]  cfg,
  input  logic [NBYTES-1:0] in_rd,
  output logic [NPINS-1:0]  snap_q,
  output logic              int_n
);
  localparam logic [1:0] PRIME_LOAD = 2'd2;
  localparam logic [1:0] PRIME_DONE = 2'd3;

  logic [1:0]       prime_q;
  logic [1:0]       prime_d;
  logic             prime_en;
  logic [NPINS-1:0] snap_d;
  logic             snap_en;
  logic [NPINS-1:0] diff;

  always_comb begin
    prime_en = (prime_q != PRIME_DONE);
    prime_d  = prime_q + 2'd1;
  end

  always_comb begin
    snap_d  = snap_q;
    snap_en = (prime_q == PRIME_LOAD) | (|in_rd);
    if (prime_q == PRIME_LOAD) begin
      snap_d = pin_lvl;
    end
    for (int b = 0; b < NBYTES; b++) begin
      if (in_rd[b]) begin
        snap_d[b*BYTE_W +: BYTE_W] = pin_lvl[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_q <= '0;
      snap_q  <= '0;
    end else begin
      if (prime_en) prime_q <= prime_d;
      if (snap_en)  snap_q  <= snap_d;
    end
  end

  assign diff  = (pin_lvl ^ snap_q) & cfg;
  assign int_n = ~((prime_q == PRIME_DONE) & (|diff));
endmodule

// File: rtl/gpx_core.sv
module gpx_core
  import gpx_pkg::*;
#(
  parameter int NPINS     = 16,
  parameter int SYNC_DEPTH = 2,
  localparam int NBYTES   = NPINS / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              dat_we,
  input  logic              rd_ack,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              int_n
);
  logic              rst_n_s;
  logic [NPINS-1:0]  sync_lvl;
  logic [BYTE_W-1:0] ptr_q;
  logic [NPINS-1:0]  out_q;
  logic [NPINS-1:0]  cfg_q;
  logic [NBYTES-1:0] in_rd;
  logic [NPINS-1:0]  snap_lvl;

  // Reset: asserted asynchronously, released after two edges
  gpx_sync #(.W(1), .STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  gpx_sync #(.W(NPINS), .STAGES(SYNC_DEPTH)) u_pins (
    .clk(clk), .rst_n(rst_n_s), .d(pin_in), .q(sync_lvl)
  );

  gpx_regfile #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .cmd_we(cmd_we), .dat_we(dat_we),
    .rd_ack(rd_ack), .wdata(wdata), .pin_lvl(sync_lvl), .ptr_q(ptr_q),
    .rd_data(rd_data), .out_q(out_q), .cfg_q(cfg_q), .in_rd(in_rd)
  );

  gpx_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n_s), .pin_lvl(sync_lvl), .cfg(cfg_q),
    .in_rd(in_rd), .snap_q(snap_lvl), .int_n(int_n)
  );

  assign pin_oe  = ~cfg_q;
  assign pin_out = out_q & ~cfg_q;
endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk
  import gpx_pkg::*;
#(
  parameter int NPINS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_we,
  input logic              dat_we,
  input logic              rd_ack,
  input logic [BYTE_W-1:0] wdata,
  input logic [BYTE_W-1:0] ptr_q,
  input logic [NPINS-1:0]  out_q,
  input logic [NPINS-1:0]  cfg_q,
  input logic [NPINS-1:0]  sync_lvl,
  input logic [NPINS-1:0]  snap_lvl,
  input logic [NPINS-1:0]  pin_oe,
  input logic              int_n
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_we, dat_we, rd_ack}));  // R2

  AST_PAIR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we || rd_ack) && !cmd_we |=> ptr_q[0] != $past(ptr_q[0]));  // R3

  AST_INPORT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we && !cmd_we && (ptr_q[BYTE_W-1:1] == '0) |=> $stable(out_q) && $stable(cfg_q));  // R4

  AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we && !cmd_we && (ptr_q == 8'd6) |=> pin_oe[BYTE_W-1:0] == ~$past(wdata));  // R5

  AST_OUTPINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&pin_oe) |-> int_n);  // R7

  AST_READ_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !cmd_we && (ptr_q == 8'd0) |=> snap_lvl[BYTE_W-1:0] == $past(sync_lvl[BYTE_W-1:0]));  // R8
endmodule

bind gpx_core gpx_core_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .cmd_we(cmd_we), .dat_we(dat_we),
  .rd_ack(rd_ack), .wdata(wdata), .ptr_q(ptr_q), .out_q(out_q),
  .cfg_q(cfg_q), .sync_lvl(sync_lvl), .snap_lvl(snap_lvl),
  .pin_oe(pin_oe), .int_n(int_n)
);

// File: tb/sim_gpx_core.sv
`timescale 1ns/1ps
module sim_gpx_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we, dat_we, rd_ack;
  logic [7:0]  wdata;
  logic [7:0]  rd_data;
  logic [15:0] pin_in, pin_out, pin_oe;
  logic        int_n;
  int          n_chk = 0;
  int          n_err = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  gpx_core u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .dat_we(dat_we),
    .rd_ack(rd_ack), .wdata(wdata), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .int_n(int_n)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cmd(logic [7:0] b);
    @(negedge clk); cmd_we = 1'b1; wdata = b;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wr_dat(logic [7:0] b);
    @(negedge clk); dat_we = 1'b1; wdata = b;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] b);
    @(negedge clk); b = rd_data; rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] b;
    chk("R1 oe", pin_oe, 16'h0000);
    chk("R1 out", pin_out, 16'h0000);
    chk("R1 int", {15'd0, int_n}, 16'h0001);
    rd_byte(b); chk("R1 ptr0 reads input low", {8'd0, b}, 16'h003C);
    rd_byte(b); chk("R3 R4 input high", {8'd0, b}, 16'h005A);
    wr_cmd(8'h02);
    rd_byte(b); chk("R1 out low", {8'd0, b}, 16'h00FF);
    rd_byte(b); chk("R1 out high", {8'd0, b}, 16'h00FF);
    wr_cmd(8'h06);
    rd_byte(b); chk("R1 dir low", {8'd0, b}, 16'h00FF);
    rd_byte(b); chk("R1 dir high", {8'd0, b}, 16'h00FF);
  endtask

  task automatic t_write();
    logic [7:0] b;
    wr_cmd(8'h02); wr_dat(8'h12); wr_dat(8'h34);
    wr_cmd(8'h06); wr_dat(8'hF0); wr_dat(8'hFF);
    chk("R5 oe", pin_oe, 16'h000F);
    chk("R5 out gated", pin_out, 16'h0002);
    wr_cmd(8'h02); wr_dat(8'hAA); wr_dat(8'hBB); wr_dat(8'hCC);
    wr_cmd(8'h02);
    rd_byte(b); chk("R3 wrap low", {8'd0, b}, 16'h00CC);
    rd_byte(b); chk("R2 R3 high", {8'd0, b}, 16'h00BB);
    rd_byte(b); chk("R3 read wrap", {8'd0, b}, 16'h00CC);
    chk("R5 out after burst", pin_out, 16'h000C);
  endtask

  task automatic t_in_ro();
    logic [7:0] b;
    wr_cmd(8'h00); wr_dat(8'h00); wr_dat(8'h00);
    wr_cmd(8'h02);
    rd_byte(b); chk("R4 out untouched", {8'd0, b}, 16'h00CC);
    wr_cmd(8'h06);
    rd_byte(b); chk("R4 dir untouched", {8'd0, b}, 16'h00F0);
    chk("R4 oe untouched", pin_oe, 16'h000F);
  endtask

  task automatic t_unmapped();
    logic [7:0] b;
    wr_cmd(8'h04);
    rd_byte(b); chk("R10 read 4", {8'd0, b}, 16'h0000);
    rd_byte(b); chk("R10 read 5", {8'd0, b}, 16'h0000);
    wr_cmd(8'h05); wr_dat(8'h55); wr_dat(8'h55);
    wr_cmd(8'h02);
    rd_byte(b); chk("R10 out kept low", {8'd0, b}, 16'h00CC);
    rd_byte(b); chk("R10 out kept high", {8'd0, b}, 16'h00BB);
    chk("R10 oe kept", pin_oe, 16'h000F);
  endtask

  task automatic t_outpin_live();
    logic [7:0] b;
    pin_in = 16'h5A33;
    idle(4);
    chk("R7 no irq from output pins", {15'd0, int_n}, 16'h0001);
    wr_cmd(8'h00);
    rd_byte(b); chk("R4 live level of output pins", {8'd0, b}, 16'h0033);
    rd_byte(b); chk("R4 high byte", {8'd0, b}, 16'h005A);
  endtask

  task automatic t_irq();
    logic [7:0] b;
    pin_in = 16'h5833;
    idle(1);
    chk("R6 not before sync", {15'd0, int_n}, 16'h0001);
    idle(1);
    chk("R6 asserted after two edges", {15'd0, int_n}, 16'h0000);
    wr_cmd(8'h00);
    rd_byte(b); chk("R8 low read keeps irq", {15'd0, int_n}, 16'h0000);
    rd_byte(b); chk("R4 high value", {8'd0, b}, 16'h0058);
    chk("R8 high read clears", {15'd0, int_n}, 16'h0001);
    pin_in = 16'h5813;
    idle(3);
    chk("R6 low byte change", {15'd0, int_n}, 16'h0000);
    wr_cmd(8'h01);
    rd_byte(b); chk("R8 other byte read keeps irq", {15'd0, int_n}, 16'h0000);
    wr_cmd(8'h00);
    rd_byte(b); chk("R8 low read value", {8'd0, b}, 16'h0013);
    chk("R8 low read clears", {15'd0, int_n}, 16'h0001);
  endtask

  task automatic t_return();
    pin_in = 16'h4813;
    idle(3);
    chk("R9 irq on change", {15'd0, int_n}, 16'h0000);
    pin_in = 16'h5813;
    idle(3);
    chk("R9 irq drops on return", {15'd0, int_n}, 16'h0001);
  endtask

  initial begin
    rst_n = 1'b0; cmd_we = 1'b0; dat_we = 1'b0; rd_ack = 1'b0;
    wdata = 8'h00; pin_in = 16'h5A3C;
    idle(3);
    rst_n = 1'b1;
    idle(10);
    t_reset();
    t_write();
    t_in_ro();
    t_unmapped();
    t_outpin_live();
    t_irq();
    t_return();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule